// File: doc/BRIEF.md
# Synthesizer Channel Programming Loader

This block turns a channel number into the two configuration words that an integer-N, dual-modulus PLL synthesizer needs, and delivers them over a three-wire serial link made of a serial clock, a data line and a load strobe. The total division ratio is the channel number plus a base ratio. That ratio is split into a programmable-counter value N (the ratio divided by the prescaler modulus M) and a swallow-counter value A (the remainder). The block first sends a reference-divider word and then a divider word. Each word is 19 bits long, sent most significant bit first, and followed by a load pulse. The synthesizer uses the last bit of each word to tell the two words apart.

A controller pulses `start_i` with a channel on `chan_i`. While the transfer runs, `busy_o` stays high. `done_o` pulses for one cycle once both words have been latched. If the channel is out of range, or if the split would give A ≥ N, the block pulses `err_o` and leaves the serial pins idle. The link timing is set by two parameters counted in system clocks: `PH_CYC` sets each serial clock phase, and `LE_CYC` sets the load strobe width and its spacing from clock edges. The defaults suit a 100 MHz system clock (20 ns phases, 100 ns strobe intervals).

Loader states: IDLE (waits for a request), CHECK (registered channel is validated), FAULT (error pulse), REF_GO / REF_WAIT (launch and wait for the reference word), DIV_GO / DIV_WAIT (launch and wait for the divider word), DONE (completion pulse). Transitions: IDLE→CHECK on `start_i`; CHECK→FAULT on an invalid split, otherwise CHECK→REF_GO; REF_GO→REF_WAIT; REF_WAIT→DIV_GO when the word has finished; DIV_GO→DIV_WAIT; DIV_WAIT→DONE when the word has finished; FAULT→IDLE and DONE→IDLE unconditionally. Serializer states: S_IDLE, S_LOW (data presented, clock low), S_HIGH (clock high), S_GAP (clock low before the strobe), S_LE (strobe high), S_TAIL (strobe low after the strobe). Transitions: S_IDLE→S_LOW on launch; S_LOW→S_HIGH when the phase count expires; S_HIGH→S_LOW when the phase count expires with bits still to send; S_HIGH→S_GAP after the 19th bit; S_GAP→S_LE, S_LE→S_TAIL and S_TAIL→S_IDLE, each when its count expires.

Top module: `pll_chan_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `syn_clk_o` and `syn_le_o` are all 0.
- R2: For channel c the divider word holds N in 11 bits, then A in 7 bits, then a 0 bit. Here n = BASE_DIV + c, N = n / PRESCALE and A = n mod PRESCALE (defaults: BASE_DIV 16455 and PRESCALE 64, so channel 0 gives N=257, A=7 and channel 68 gives N=258, A=11).
- R3: The reference word is, from first bit sent to last: 0, 0, 1, a prescaler select bit (1 when PRESCALE is 64, else 0), REF_DIV in 14 bits (default 850), then a 1 bit.
- R4: Each accepted request produces exactly two load pulses: the reference word first, then the divider word. Every word has exactly 19 serial clock rises, and its bits are sent most significant first.
- R5: `syn_data_o` changes only while `syn_clk_o` is low. Each high phase and each low phase of `syn_clk_o` lasts at least PH_CYC cycles.
- R6: `syn_le_o` is low whenever `syn_clk_o` is high. Each load pulse is high for at least LE_CYC cycles. It starts at least LE_CYC cycles after the last clock fall, and the next clock rise comes at least LE_CYC cycles after it ends.
- R7: `busy_o` rises in the cycle after an accepted request and stays high until the cycle in which `done_o` or `err_o` pulses. `done_o` is a single-cycle pulse, and the serial pins are idle whenever `busy_o` is low.
- R8: A request made while `busy_o` is high is ignored. The words sent still belong to the first channel, and no further transfer follows.
- R9: A channel number of CH_COUNT (default 69) or above gives a single-cycle `err_o` pulse, no `done_o`, and no serial clock or load activity.
- R10: A channel whose split gives A ≥ N is rejected in the same way as in R9 (for BASE_DIV 192, channel 3 gives N=3, A=3 and is rejected, while channel 2 is accepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; sampled only when the block is idle |
| chan_i | input | CH_W | Channel number captured with the request |
| syn_clk_o | output | 1 | Serial clock to the synthesizer |
| syn_data_o | output | 1 | Serial data, sampled by the synthesizer on the clock rise |
| syn_le_o | output | 1 | Load strobe; a rise latches the shifted word |
| busy_o | output | 1 | High from the accepted request up to the done or error pulse |
| done_o | output | 1 | One-cycle pulse after both words are loaded |
| err_o | output | 1 | One-cycle pulse when the channel is rejected |

## Verification
The bound assertions check the link discipline on every cycle: data holds steady while the clock is high, the strobe never overlaps a clock high phase, the minimum widths hold for clock phases and strobes, done and error are single pulses that never coincide, and the pins are quiet while idle. The content and order of the words, the N/A split over every channel, the rejection of out-of-range channels and of A ≥ N splits, and the dropping of requests made during a transfer can only be shown by the bench scenarios. The bench decodes the serial stream and compares it with words it computes from the channel number.

// File: rtl/pll_ldr_pkg.sv
package pll_ldr_pkg;

    localparam int WORD_W = 19;
    localparam int N_W    = 11;
    localparam int A_W    = 7;
    localparam int R_W    = 14;

    typedef enum logic [2:0] {
        S_IDLE, S_LOW, S_HIGH, S_GAP, S_LE, S_TAIL
    } tx_state_t;

    typedef enum logic [2:0] {
        T_IDLE, T_CHECK, T_FAULT, T_REF_GO, T_REF_WAIT, T_DIV_GO, T_DIV_WAIT, T_DONE
    } ldr_state_t;

    // reference word: charge pump 0, lock-detect output 0, phase polarity 1, prescaler select, R, tag 1
    function automatic logic [WORD_W-1:0] make_ref_word(input logic [R_W-1:0] r_div, input logic sw);
        return {1'b0, 1'b0, 1'b1, sw, r_div, 1'b1};
    endfunction

    // divider word: N, A, tag 0
    function automatic logic [WORD_W-1:0] make_div_word(input logic [N_W-1:0] n_cnt, input logic [A_W-1:0] a_cnt);
        return {n_cnt, a_cnt, 1'b0};
    endfunction

endpackage

// File: rtl/pll_div_split.sv
module pll_div_split
    import pll_ldr_pkg::*;
#(
    parameter int BASE_DIV = 16455,
    parameter int PRESCALE = 64,
    parameter int CH_COUNT = 69,
    parameter int CH_W     = 7
) (
    input  logic [CH_W-1:0] chan_i,
    output logic [N_W-1:0]  n_cnt_o,
    output logic [A_W-1:0]  a_cnt_o,
    output logic            ok_o
);
    localparam int M_LOG = $clog2(PRESCALE);
    localparam int TOT_W = N_W + A_W;
    localparam logic [TOT_W-1:0] A_MASK = TOT_W'(PRESCALE - 1);

    logic [TOT_W-1:0] total;
    logic             in_range;

    always_comb begin
        total    = TOT_W'(BASE_DIV) + TOT_W'(chan_i);
        n_cnt_o  = N_W'(total >> M_LOG);
        a_cnt_o  = A_W'(total & A_MASK);
        in_range = (int'(chan_i) < CH_COUNT);
        ok_o     = in_range && ({4'b0, a_cnt_o} < n_cnt_o);
    end
endmodule

// File: rtl/pll_serial_tx.sv
module pll_serial_tx
    import pll_ldr_pkg::*;
#(
    parameter int PH_CYC = 2,
    parameter int LE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sle_o,
    output logic              fin_o
);
    localparam int MAX_CYC = (PH_CYC > LE_CYC) ? PH_CYC : LE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int IDX_W   = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] PH_LOAD = CNT_W'(PH_CYC - 1);
    localparam logic [CNT_W-1:0] LE_LOAD = CNT_W'(LE_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    tx_state_t         st, st_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [WORD_W-1:0] sreg;
    logic              expired;

    assign expired = (cnt == '0);
    assign sdata_o = sreg[WORD_W-1];

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE: if (go_i)    st_nxt = S_LOW;
            S_LOW:  if (expired) st_nxt = S_HIGH;
            S_HIGH: if (expired) st_nxt = (bit_idx == LAST_IDX) ? S_GAP : S_LOW;
            S_GAP:  if (expired) st_nxt = S_LE;
            S_LE:   if (expired) st_nxt = S_TAIL;
            S_TAIL: if (expired) st_nxt = S_IDLE;
            default:             st_nxt = S_IDLE;
        endcase
    end

    // state register with its counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            sreg    <= '0;
        end else begin
            st <= st_nxt;
            if (st_nxt != st)
                cnt <= (st_nxt == S_LOW || st_nxt == S_HIGH) ? PH_LOAD : LE_LOAD;
            else if (!expired)
                cnt <= cnt - 1'b1;
            if (st == S_IDLE && go_i) begin
                sreg    <= word_i;
                bit_idx <= '0;
            end else if (st == S_HIGH && st_nxt == S_LOW) begin
                sreg    <= {sreg[WORD_W-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_o <= 1'b0;
            sle_o  <= 1'b0;
            fin_o  <= 1'b0;
        end else begin
            sclk_o <= (st_nxt == S_HIGH);
            sle_o  <= (st_nxt == S_LE);
            fin_o  <= (st == S_TAIL) && expired;
        end
    end
endmodule

// File: rtl/pll_chan_loader.sv
module pll_chan_loader
    import pll_ldr_pkg::*;
#(
    parameter int BASE_DIV = 16455,
    parameter int PRESCALE = 64,
    parameter int REF_DIV  = 850,
    parameter int CH_COUNT = 69,
    parameter int CH_W     = 7,
    parameter int PH_CYC   = 2,
    parameter int LE_CYC   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CH_W-1:0] chan_i,
    output logic            syn_clk_o,
    output logic            syn_data_o,
    output logic            syn_le_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o
);
    localparam logic             SW_BIT  = (PRESCALE == 64);
    localparam logic [R_W-1:0]   R_FIELD = R_W'(REF_DIV);

    ldr_state_t        st, st_nxt;
    logic [CH_W-1:0]   chan_q;
    logic [N_W-1:0]    n_cnt;
    logic [A_W-1:0]    a_cnt;
    logic              split_ok;
    logic              tx_go, tx_fin;
    logic [WORD_W-1:0] tx_word;

    pll_div_split #(
        .BASE_DIV(BASE_DIV), .PRESCALE(PRESCALE), .CH_COUNT(CH_COUNT), .CH_W(CH_W)
    ) split_i (
        .chan_i(chan_q), .n_cnt_o(n_cnt), .a_cnt_o(a_cnt), .ok_o(split_ok)
    );

    assign tx_go   = (st == T_REF_GO) || (st == T_DIV_GO);
    assign tx_word = (st == T_REF_GO) ? make_ref_word(R_FIELD, SW_BIT)
                                      : make_div_word(n_cnt, a_cnt);

    pll_serial_tx #(.PH_CYC(PH_CYC), .LE_CYC(LE_CYC)) tx_i (
        .clk(clk), .rst_n(rst_n), .go_i(tx_go), .word_i(tx_word),
        .sclk_o(syn_clk_o), .sdata_o(syn_data_o), .sle_o(syn_le_o), .fin_o(tx_fin)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            T_IDLE:     if (start_i) st_nxt = T_CHECK;
            T_CHECK:    st_nxt = split_ok ? T_REF_GO : T_FAULT;
            T_FAULT:    st_nxt = T_IDLE;
            T_REF_GO:   st_nxt = T_REF_WAIT;
            T_REF_WAIT: if (tx_fin) st_nxt = T_DIV_GO;
            T_DIV_GO:   st_nxt = T_DIV_WAIT;
            T_DIV_WAIT: if (tx_fin) st_nxt = T_DONE;
            T_DONE:     st_nxt = T_IDLE;
            default:    st_nxt = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= T_IDLE;
            chan_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == T_IDLE && start_i)
                chan_q <= chan_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            busy_o <= (st_nxt != T_IDLE);
            done_o <= (st_nxt == T_DONE);
            err_o  <= (st_nxt == T_FAULT);
        end
    end
endmodule

// File: rtl/pll_chan_loader_chk.sv
module pll_chan_loader_chk #(
    parameter int PH_CYC = 2,
    parameter int LE_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic syn_clk_o,
    input logic syn_data_o,
    input logic syn_le_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    logic [15:0] hi_run, lo_run, le_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= 16'hffff;
            le_run <= '0;
        end else begin
            hi_run <= syn_clk_o ? ((hi_run == 16'hffff) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= syn_clk_o ? '0 : ((lo_run == 16'hffff) ? lo_run : lo_run + 1'b1);
            le_run <= syn_le_o  ? ((le_run == 16'hffff) ? le_run : le_run + 1'b1) : '0;
        end
    end

    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_clk_o && $past(syn_clk_o)) |-> $stable(syn_data_o)); // R5
    AST_CLK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_clk_o) |-> (hi_run >= 16'(PH_CYC))); // R5
    AST_CLK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_clk_o) |-> (lo_run >= 16'(PH_CYC))); // R5
    AST_LE_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        syn_le_o |-> !syn_clk_o); // R6
    AST_LE_WIDTH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_le_o) |-> (le_run >= 16'(LE_CYC))); // R6
    AST_LE_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_le_o) |-> (lo_run >= 16'(LE_CYC))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!syn_clk_o && !syn_le_o)); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!syn_clk_o && !syn_le_o)); // R9
endmodule

bind pll_chan_loader pll_chan_loader_chk #(.PH_CYC(PH_CYC), .LE_CYC(LE_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .syn_clk_o(syn_clk_o), .syn_data_o(syn_data_o),
    .syn_le_o(syn_le_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/pll_chan_loader_tb_top.sv
module pll_chan_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 2;
    localparam int LE = 10;
    localparam int WAIT_MAX = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0, start_b = 1'b0;
    logic [6:0] chan_a = '0, chan_b = '0;
    logic sclk_a, sdata_a, le_a, busy_a, done_a, err_a;
    logic sclk_b, sdata_b, le_b, busy_b, done_b, err_b;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_chan_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .chan_i(chan_a),
        .syn_clk_o(sclk_a), .syn_data_o(sdata_a), .syn_le_o(le_a),
        .busy_o(busy_a), .done_o(done_a), .err_o(err_a)
    );

    pll_chan_loader #(.BASE_DIV(192), .CH_COUNT(8)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .chan_i(chan_b),
        .syn_clk_o(sclk_b), .syn_data_o(sdata_b), .syn_le_o(le_b),
        .busy_o(busy_b), .done_o(done_b), .err_o(err_b)
    );

    // serial link monitor on the main instance
    logic [18:0] cap [0:255];
    logic [18:0] shreg = '0;
    int nw = 0, nbits = 0, tviol = 0, rises = 0;
    int hi_run = 0, lo_run = 1000, le_run = 0, since_le = 1000, since_fall = 1000;
    logic p_sclk = 1'b0, p_le = 1'b0, p_sdata = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_a && !p_sclk) begin
                if (lo_run < PH) tviol++;
                if (le_a) tviol++;
                if (since_le < LE) tviol++;
                shreg = {shreg[17:0], sdata_a};
                nbits++;
                rises++;
            end
            if (!sclk_a && p_sclk && hi_run < PH) tviol++;
            if (sclk_a && p_sclk && sdata_a != p_sdata) tviol++;
            if (le_a && !p_le) begin
                if (since_fall < LE) tviol++;
                if (nbits != 19) tviol++;
                cap[nw % 256] = shreg;
                nw++;
                nbits = 0;
            end
            if (!le_a && p_le && le_run < LE) tviol++;
            hi_run     = sclk_a ? hi_run + 1 : 0;
            lo_run     = sclk_a ? 0 : lo_run + 1;
            since_fall = sclk_a ? 0 : since_fall + 1;
            le_run     = le_a ? le_run + 1 : 0;
            since_le   = le_a ? 0 : since_le + 1;
            p_sclk = sclk_a; p_le = le_a; p_sdata = sdata_a;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_ref();
        return {1'b0, 1'b0, 1'b1, 1'b1, 14'd850, 1'b1};
    endfunction

    function automatic logic [18:0] exp_div(input int ch, input int base);
        int n = base + ch;
        return {11'(n / 64), 7'(n % 64), 1'b0};
    endfunction

    // request on the main instance; returns outcome flags
    task automatic req_a(input int ch, output bit got_done, output bit got_err);
        got_done = 0; got_err = 0;
        @(negedge clk); start_a = 1'b1; chan_a = 7'(ch);
        @(negedge clk); start_a = 1'b0;
        chk(busy_a, "R7 busy after request", 32'(busy_a), 1);
        for (int i = 0; i < WAIT_MAX && !got_done && !got_err; i++) begin
            @(negedge clk);
            if (done_a) got_done = 1;
            if (err_a)  got_err = 1;
        end
        @(negedge clk);
        chk(!done_a && !err_a, "R7 single pulse", {done_a, err_a}, 0);
        chk(!busy_a, "R7 busy released", 32'(busy_a), 0);
    endtask

    task automatic req_b(input int ch, output bit got_done, output bit got_err);
        got_done = 0; got_err = 0;
        @(negedge clk); start_b = 1'b1; chan_b = 7'(ch);
        @(negedge clk); start_b = 1'b0;
        for (int i = 0; i < WAIT_MAX && !got_done && !got_err; i++) begin
            @(negedge clk);
            if (done_b) got_done = 1;
            if (err_b)  got_err = 1;
            if (sclk_b || le_b) got_done = got_done;
        end
    endtask

    initial begin
        bit d, e;
        int base, r0;
        repeat (3) @(negedge clk);
        chk(!busy_a && !done_a && !err_a && !sclk_a && !le_a, "R1 reset outputs",
            {busy_a, done_a, err_a, sclk_a, le_a}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_a && !sclk_a && !le_a, "R1 idle after reset", {busy_a, sclk_a, le_a}, 0);

        // full sweep of valid channels
        for (int ch = 0; ch < 69; ch++) begin
            base = nw;
            req_a(ch, d, e);
            chk(d && !e, "R7 done for valid channel", {d, e}, 2);
            chk(nw - base == 2, "R4 two load pulses", nw - base, 2);
            chk(cap[base % 256] == exp_ref(), "R3 reference word first",
                cap[base % 256], exp_ref());
            chk(cap[(base + 1) % 256] == exp_div(ch, 16455), "R2 divider word",
                cap[(base + 1) % 256], exp_div(ch, 16455));
        end
        chk(exp_div(0, 16455) == {11'd257, 7'd7, 1'b0}, "R2 channel 0 split",
            exp_div(0, 16455), {11'd257, 7'd7, 1'b0});
        chk(exp_div(68, 16455) == {11'd258, 7'd11, 1'b0}, "R2 channel 68 split",
            exp_div(68, 16455), {11'd258, 7'd11, 1'b0});

        // out-of-range channels
        for (int ch = 69; ch < 128; ch++) begin
            base = nw; r0 = rises;
            req_a(ch, d, e);
            chk(e && !d, "R9 error on out-of-range channel", {d, e}, 1);
            chk(nw == base && rises == r0, "R9 no serial activity", nw - base, 0);
        end

        // request during busy is dropped
        base = nw;
        @(negedge clk); start_a = 1'b1; chan_a = 7'd5;
        @(negedge clk); start_a = 1'b0;
        repeat (30) @(negedge clk);
        start_a = 1'b1; chan_a = 7'd40;
        @(negedge clk); start_a = 1'b0;
        for (int i = 0; i < WAIT_MAX && !done_a; i++) @(negedge clk);
        repeat (400) @(negedge clk);
        chk(nw - base == 2, "R8 only one transfer", nw - base, 2);
        chk(cap[(base + 1) % 256] == exp_div(5, 16455), "R8 first channel kept",
            cap[(base + 1) % 256], exp_div(5, 16455));
        chk(!busy_a, "R8 no second transfer", 32'(busy_a), 0);

        // A >= N rejection on the small configuration
        req_b(3, d, e);
        chk(e && !d, "R10 channel 3 rejected (A=N=3)", {d, e}, 1);
        req_b(2, d, e);
        chk(d && !e, "R10 channel 2 accepted (A=2,N=3)", {d, e}, 2);
        req_b(8, d, e);
        chk(e && !d, "R9 small range limit", {d, e}, 1);

        chk(tviol == 0, "R5 R6 link timing violations", tviol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end
endmodule